// File: doc/BRIEF.md
# SPI Master Transmit Feeder with Filler Words

This block sits between the software-facing transmit path and the serial shift register of an SPI controller. Words arrive on a valid/ready write stream together with a size code. Each word is checked against the configured access width, trimmed to that width, and queued in a small transmit buffer. The shift register takes words from a second valid/ready port, the load port. When the buffer holds a word, the oldest one is offered there.

When the buffer is empty, the block can still keep the serial link moving. In master mode, with filler enabled, it offers the word it loaded most recently again. A filler that is offered before any real word has left since reset carries zeros and is flagged as undefined. In slave mode, or with filler disabled, an empty buffer offers nothing.

A small control image holds the filler enable and the access width. Writes to it are refused while a transfer is in progress.

Back-pressure rules are as follows. A write is taken on any cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low only while the buffer is full. A taken write whose size does not match the configured width is consumed and dropped. A load happens on any cycle where both `ld_valid` and `ld_ready` are high. While `ld_ready` is low, the offered word is held.

Top module: `sptx_feeder`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h20 (filler off, byte width), `ld_valid`, `size_err` and `cfg_err` are 0, and `wr_ready` is 1.
- R2: A control write with `xfer_idle`=1 and a nonzero width field takes effect on the next cycle. Bit 7 is the filler enable. Bits 6:5 are the width: 01 byte, 10 16-bit, 11 32-bit. Bits 4:0 always read 0.
- R3: A control write made while `xfer_idle`=0 leaves `cfg_rdata` unchanged and sets `cfg_err`, which stays 1 until reset.
- R4: A control write whose width field is 00 leaves `cfg_rdata` unchanged and sets `cfg_err`.
- R5: A taken write whose `wr_size` equals the configured width code is queued. It is zero-extended from its low 8, 16 or 32 bits, and queued words leave in arrival order.
- R6: A taken write whose `wr_size` differs from the configured width is not queued. `size_err` is 1 on the following cycle only.
- R7: `wr_ready` is 0 exactly while DEPTH words are queued, and a write offered then is not taken.
- R8: With at least one word queued, `ld_valid`=1, `ld_data` is the oldest word and `ld_dummy`=0. The word is removed only on a cycle with `ld_ready`=1.
- R9: With the buffer empty, `master`=1 and filler enabled, `ld_valid`=1, `ld_dummy`=1 and `ld_data` equals the last word loaded, filler words included.
- R10: With the buffer empty, `ld_valid`=0 if filler is disabled or `master`=0.
- R11: A filler offered before any real word has been loaded since reset has `ld_data`=0 and `ld_undef`=1. Otherwise `ld_undef`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master | input | 1 | 1 = master mode |
| xfer_idle | input | 1 | Transfer-complete flag, 1 = no transfer in progress |
| cfg_we | input | 1 | Control image write strobe |
| cfg_wdata | input | 8 | Control image write value |
| cfg_rdata | output | 8 | Control image read value |
| cfg_err | output | 1 | Sticky refused-control-write flag |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 32 | Write stream data |
| wr_size | input | 2 | Write size code, same encoding as the width field |
| size_err | output | 1 | One-cycle pulse after a dropped mismatched write |
| ld_valid | output | 1 | Load port valid |
| ld_ready | input | 1 | Shift register accepts a word |
| ld_data | output | 32 | Word offered to the shift register |
| ld_dummy | output | 1 | Offered word is a filler repeat |
| ld_undef | output | 1 | Offered filler has no real predecessor |

## Verification
The write stream and the load port can fire in the same cycle while the buffer is empty and filler is on. In that case the filler repeat must be loaded and the new word must be queued, not bypassed. The bench provokes this by raising `wr_valid` and `ld_ready` in one cycle with an empty buffer. It then checks that the word loaded was the old filler, that the next offer is the new word as a real load, and that the filler after it repeats that new word. A sweep over every width and size pairing also checks each control write's effect against the write-size outcome.

// File: rtl/sptx_pkg.sv
package sptx_pkg;
  typedef enum logic [1:0] {
    AW_NONE = 2'b00,
    AW_BYTE = 2'b01,
    AW_HALF = 2'b10,
    AW_FULL = 2'b11
  } acc_width_e;

  localparam logic [7:0] CFG_RESET = 8'h20;
  localparam int CFG_DUMMY_BIT = 7;
  localparam int CFG_WIDTH_LSB = 5;

  typedef struct packed {
    logic       dummy_en;
    acc_width_e width;
  } cfg_t;
endpackage

// File: rtl/sptx_cfg_reg.sv
module sptx_cfg_reg
  import sptx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       xfer_idle,
  output cfg_t       cfg,
  output logic [7:0] cfg_rdata,
  output logic       cfg_err
);
  logic       refuse;
  acc_width_e new_width;
  logic [4:0] unused_rsvd;

  assign new_width   = acc_width_e'(cfg_wdata[CFG_WIDTH_LSB +: 2]);
  assign refuse      = !xfer_idle || (new_width == AW_NONE);
  assign unused_rsvd = cfg_wdata[4:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.dummy_en <= CFG_RESET[CFG_DUMMY_BIT];
      cfg.width    <= acc_width_e'(CFG_RESET[CFG_WIDTH_LSB +: 2]);
      cfg_err      <= 1'b0;
    end else if (cfg_we) begin
      if (refuse) begin
        cfg_err <= 1'b1;
      end else begin
        cfg.dummy_en <= cfg_wdata[CFG_DUMMY_BIT];
        cfg.width    <= new_width;
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    cfg_rdata[CFG_DUMMY_BIT] = cfg.dummy_en;
    cfg_rdata[CFG_WIDTH_LSB +: 2] = cfg.width;
  end
endmodule

// File: rtl/sptx_width_gate.sv
module sptx_width_gate
  import sptx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  input  acc_width_e        width,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              size_err
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic taken;
  logic match;

  assign taken = wr_valid && wr_ready;
  assign match = (wr_size == width) && (width != AW_NONE);
  assign push  = taken && match;

  always_comb begin
    push_data = '0;
    unique case (width)
      AW_BYTE: push_data[BYTE_W-1:0] = wr_data[BYTE_W-1:0];
      AW_HALF: push_data[HALF_W-1:0] = wr_data[HALF_W-1:0];
      AW_FULL: push_data = wr_data;
      default: push_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_err <= 1'b0;
    else        size_err <= taken && !match;
  end
endmodule

// File: rtl/sptx_txbuf.sv
module sptx_txbuf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot[rptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot[i] <= '0;
      else if (do_push && wptr == PTR_W'(i))     slot[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sptx_load_sel.sv
module sptx_load_sel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  input  logic              master,
  input  logic              dummy_en,
  input  logic              ld_ready,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_dummy,
  output logic              ld_undef,
  output logic              pop
);
  logic [DATA_W-1:0] last_sent;
  logic              have_real;
  logic              filler_ok;
  logic              fire;

  assign filler_ok = master && dummy_en;
  assign ld_dummy  = empty && filler_ok;
  assign ld_valid  = !empty || filler_ok;
  assign ld_data   = empty ? last_sent : head;
  assign ld_undef  = ld_dummy && !have_real;
  assign fire      = ld_valid && ld_ready;
  assign pop       = fire && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_sent <= '0;
      have_real <= 1'b0;
    end else if (fire) begin
      last_sent <= ld_data;
      if (!empty) have_real <= 1'b1;
    end
  end
endmodule

// File: rtl/sptx_feeder.sv
module sptx_feeder
  import sptx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              xfer_idle,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cfg_err,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  output logic              size_err,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_dummy,
  output logic              ld_undef
);
  cfg_t              cfg;
  logic              push, pop, empty, full;
  logic [DATA_W-1:0] push_data, head;

  assign wr_ready = !full;

  sptx_cfg_reg u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .xfer_idle,
    .cfg(cfg), .cfg_rdata, .cfg_err
  );

  sptx_width_gate #(.DATA_W(DATA_W)) u_gate (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_data, .wr_size,
    .width(cfg.width), .push, .push_data, .size_err
  );

  sptx_txbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk, .rst_n, .push, .push_data, .pop, .head, .empty, .full
  );

  sptx_load_sel #(.DATA_W(DATA_W)) u_sel (
    .clk, .rst_n, .empty, .head, .master, .dummy_en(cfg.dummy_en),
    .ld_ready, .ld_valid, .ld_data, .ld_dummy, .ld_undef, .pop
  );
endmodule

// File: rtl/sptx_feeder_chk.sv
module sptx_feeder_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master,
  input logic              xfer_idle,
  input logic              cfg_we,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic              cfg_err,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        wr_size,
  input logic              size_err,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [DATA_W-1:0] ld_data,
  input logic              ld_dummy,
  input logic              ld_undef
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4:0] == 5'd0); // R2
  AST_BUSY_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !xfer_idle) |=> ($stable(cfg_rdata) && cfg_err)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R3
  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6:5] != 2'b00); // R4
  AST_SIZE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(wr_valid && wr_ready)); // R6
  AST_FULL_NO_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (ld_valid && !ld_dummy)); // R7
  AST_FILLER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dummy |-> (master && cfg_rdata[7] && ld_valid)); // R10
  AST_FILLER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (!ld_dummy || ld_data == $past(ld_data))); // R9
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld_undef |-> (ld_dummy && ld_data == '0)); // R11
endmodule

bind sptx_feeder sptx_feeder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sptx_feeder.sv
`timescale 1ns/1ps
module tb_sptx_feeder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b1, xfer_idle = 1'b1, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        cfg_err, wr_valid = 1'b0, wr_ready, size_err;
  logic [31:0] wr_data = '0, ld_data;
  logic [1:0]  wr_size = '0;
  logic        ld_valid, ld_ready = 1'b0, ld_dummy, ld_undef;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  sptx_feeder #(.DATA_W(32), .DEPTH(4)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [7:0] v, logic idle);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v; xfer_idle = idle;
    @(negedge clk); cfg_we = 1'b0; xfer_idle = 1'b1; #1;
  endtask

  task automatic push(logic [31:0] d, logic [1:0] s);
    @(negedge clk); wr_valid = 1'b1; wr_data = d; wr_size = s;
    @(negedge clk); wr_valid = 1'b0; #1;
  endtask

  task automatic pop1();
    @(negedge clk); ld_ready = 1'b1;
    @(negedge clk); ld_ready = 1'b0; #1;
  endtask

  function automatic logic [31:0] trim(logic [31:0] d, int w);
    case (w)
      1: return d & 32'h0000_00FF;
      2: return d & 32'h0000_FFFF;
      default: return d;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, y;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R1 reset state
    chk("R1 cfg_rdata", cfg_rdata, 32'h20);
    chk("R1 ld_valid", ld_valid, 0);
    chk("R1 size_err", size_err, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 wr_ready", wr_ready, 1);

    // R2 accepted write, reserved bits read zero
    cfg_wr(8'hBF, 1'b1);
    chk("R2 rsvd masked", cfg_rdata, 32'hA0);
    // R11 filler before any real word
    chk("R11 valid", ld_valid, 1);
    chk("R11 dummy", ld_dummy, 1);
    chk("R11 undef", ld_undef, 1);
    chk("R11 data zero", ld_data, 0);
    pop1();
    chk("R11 still undef", ld_undef, 1);
    // R10 slave ignores filler enable
    master = 1'b0; #1;
    chk("R10 slave no offer", ld_valid, 0);
    master = 1'b1;

    // R5/R6 sweep over every width and size pairing, filler off
    for (int w = 1; w < 4; w++) begin
      cfg_wr(8'(w << 5), 1'b1);
      chk("R2 width", cfg_rdata, 32'(w << 5));
      chk("R10 filler off", ld_valid, 0);
      for (int s = 0; s < 4; s++) begin
        x = 32'h9E71_A5C3 + 32'(w) * 32'h0101_0101 + 32'(s) * 32'h1111;
        push(x, 2'(s));
        chk("R6 size_err pulse", size_err, (s != w) ? 1 : 0);
        chk("R5/R6 queued", ld_valid, (s == w) ? 1 : 0);
        if (s == w) begin
          chk("R5 trimmed data", ld_data, trim(x, w));
          chk("R8 real word", ld_dummy, 0);
          @(negedge clk); #1;
          chk("R8 held without ready", ld_valid, 1);
          pop1();
          chk("R8 removed", ld_valid, 0);
        end
        @(negedge clk); #1;
        chk("R6 pulse one cycle", size_err, 0);
      end
    end

    // R7 fill, back-pressure, order
    cfg_wr(8'h60, 1'b1);
    for (int i = 0; i < 4; i++) push(32'hC0DE_0000 + 32'(i), 2'b11);
    chk("R7 full", wr_ready, 0);
    push(32'hDEAD_BEEF, 2'b11);
    chk("R7 no size_err when not taken", size_err, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 order", ld_data, 32'hC0DE_0000 + 32'(i));
      pop1();
      chk("R7 ready after pop", wr_ready, 1);
    end
    chk("R7 overflow word dropped", ld_valid, 0);

    // R9 filler repeats the last word loaded
    cfg_wr(8'hE0, 1'b1);
    chk("R9 valid", ld_valid, 1);
    chk("R9 dummy", ld_dummy, 1);
    chk("R11 defined", ld_undef, 0);
    chk("R9 repeat", ld_data, 32'hC0DE_0003);
    pop1(); pop1();
    chk("R9 repeat after filler", ld_data, 32'hC0DE_0003);
    master = 1'b0; #1;
    chk("R10 slave", ld_valid, 0);
    master = 1'b1;

    // R9 write and filler load in the same cycle
    x = 32'h1234_5678;
    @(negedge clk); wr_valid = 1'b1; wr_data = x; wr_size = 2'b11; ld_ready = 1'b1; #1;
    chk("R9 concurrent filler", ld_dummy, 1);
    chk("R9 concurrent data", ld_data, 32'hC0DE_0003);
    @(negedge clk); wr_valid = 1'b0; ld_ready = 1'b0; #1;
    chk("R5 queued not bypassed", ld_dummy, 0);
    chk("R5 new word", ld_data, x);
    pop1();
    chk("R9 filler is new word", ld_data, x);
    chk("R9 dummy flag", ld_dummy, 1);

    // R4 width 00 refused
    y = {24'h0, cfg_rdata};
    cfg_wr(8'h80, 1'b1);
    chk("R4 unchanged", cfg_rdata, y);
    chk("R4 cfg_err", cfg_err, 1);
    // R3 busy write refused, error sticky
    cfg_wr(8'h40, 1'b0);
    chk("R3 unchanged", cfg_rdata, y);
    repeat (3) @(negedge clk); #1;
    chk("R3 sticky", cfg_err, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule